// File: doc/BRIEF.md
# Codec Output Mixer with Overflow Flags

This block sits in front of a stereo DAC. Each cycle that `in_valid` is high it takes two stereo 16-bit signed sample pairs. One pair comes from the ADC path and one from the routing-matrix path. A 2-bit select register decides which of the two streams reach a saturating adder. Either stream can pass alone, the two can be summed, or the output can be silenced. The mixed sample then goes through a per-channel attenuator with sixteen steps of 1.5 dB each. The attenuated pair appears on the output two clock cycles after it was presented.

When a sum leaves the signed 16-bit range, the adder clamps it and raises a sticky overflow flag for that channel. Software clears each flag by writing a one to its bit. The block also holds the per-channel input gain setting, which it hands unchanged to the ADC front end on the `gain_l` and `gain_r` pins.

Software reaches every setting through a byte-wide write port and a combinational read port. Addresses: 0 input select, 1 input gain, 2 left attenuation, 3 right attenuation, 4 overflow status. Unmapped addresses read as zero and ignore writes.

Top module: `codec_out_mixer`

## Requirements
- R1: After a synchronous reset, the registers read as follows: select 0x03, gain 0x88, both attenuation registers 0x00, status 0x00. `out_valid`, `out_l` and `out_r` are 0 and `gain_l` and `gain_r` are 8.
- R2: `out_valid` rises exactly two cycles after a cycle with `in_valid` high. It is low otherwise, and `out_l`/`out_r` hold their last value while it is low.
- R3: In the select register (address 0), bit 0 admits the ADC pair and bit 1 admits the matrix pair. With both bits set, the two pairs are added per channel. With neither set, the mixed value is 0. Only bits 1:0 are stored; the other bits read 0.
- R4: A sum above 32767 becomes 32767 and a sum below -32768 becomes -32768 before attenuation.
- R5: Status register (address 4): bit 0 is set when the right-channel sum saturated and bit 1 when the left-channel sum saturated. No flag is set without a saturating sum. The flags also appear on `ovf_flags` with the same bit positions.
- R6: Flags are sticky. Writing 1 to a status bit clears it and writing 0 leaves it. If a clear and a new overflow on the same bit fall in one cycle, the bit ends up set.
- R7: Left attenuation step k_l is bits 3:0 of address 2 and right step k_r is bits 7:4 of address 3. The remaining bits of both registers read 0.
- R8: Output = trunc_toward_zero(x * C[k] / 32768), where C[k] = floor(32768 * 10^(-1.5k/20)), i.e. C = 32768, 27570, 23197, 19518, 16422, 13818, 11626, 9782, 8230, 6925, 5827, 4902, 4125, 3470, 2920, 2457 for k = 0..15.
- R9: The gain register (address 1) holds left gain in bits 7:4 and right gain in bits 3:0. These drive `gain_l` and `gain_r`, which change only when address 1 is written.
- R10: A write to an unmapped address (5..7) changes no register, and reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| in_valid | input | 1 | Input sample pairs are valid this cycle |
| adc_l | input | 16 | ADC stream, left, signed |
| adc_r | input | 16 | ADC stream, right, signed |
| mux_l | input | 16 | Matrix stream, left, signed |
| mux_r | input | 16 | Matrix stream, right, signed |
| out_valid | output | 1 | Output pair valid |
| out_l | output | 16 | Attenuated left sample, signed |
| out_r | output | 16 | Attenuated right sample, signed |
| ovf_flags | output | 2 | Sticky overflow flags, bit 1 left, bit 0 right |
| gain_l | output | 4 | Left input gain step for the ADC front end |
| gain_r | output | 4 | Right input gain step for the ADC front end |

## Verification
The assertions assume that `in_valid` and `reg_we` are low throughout reset. They also assume that the select and attenuation registers are not rewritten while a sample is still in the two-stage pipeline, because each stage reads the register value of its own cycle. The bench issues one sample at a time and waits for it to leave the pipeline before touching a register. The single exception is the deliberate same-cycle overflow-and-clear case. The bench sweeps every select code over a grid of extreme and ordinary values and every attenuation step on both channels, and computes expectations in plain integer arithmetic.

// File: rtl/mixer_pkg.sv
// Package: shared widths, register addresses and the attenuation coefficient
// lookup for the codec output mixer.
// Assumes 4-bit attenuation steps of 1.5 dB and Q15 coefficients.
package mixer_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int STEP_W    = 4;
    localparam int COEF_FRAC = 15;
    localparam int COEF_W    = COEF_FRAC + 2;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;

    localparam logic [ADDR_W-1:0] A_SEL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_GAIN = 3'd1;
    localparam logic [ADDR_W-1:0] A_ATTL = 3'd2;
    localparam logic [ADDR_W-1:0] A_ATTR = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    // Q15 scale factor for an attenuation step: floor(32768 * 10^(-0.075*k)).
    function automatic logic [COEF_W-1:0] atten_coef(input logic [STEP_W-1:0] step);
        case (step)
            4'd0:    return 17'd32768;
            4'd1:    return 17'd27570;
            4'd2:    return 17'd23197;
            4'd3:    return 17'd19518;
            4'd4:    return 17'd16422;
            4'd5:    return 17'd13818;
            4'd6:    return 17'd11626;
            4'd7:    return 17'd9782;
            4'd8:    return 17'd8230;
            4'd9:    return 17'd6925;
            4'd10:   return 17'd5827;
            4'd11:   return 17'd4902;
            4'd12:   return 17'd4125;
            4'd13:   return 17'd3470;
            4'd14:   return 17'd2920;
            default: return 17'd2457;
        endcase
    endfunction
endpackage

// File: rtl/mix_regs.sv
// Module: register file of the mixer. It holds input select, input gain, the
// two attenuation steps and the sticky overflow flags (write-one-to-clear),
// and returns the addressed register on a combinational read port.
// Assumes a single write port; when a flag is set and cleared in the same
// cycle, the set takes priority.
module mix_regs
    import mixer_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    ovf_set,
    output logic [1:0]    sel,
    output logic [2*SW-1:0] gain,
    output logic [SW-1:0] att_l,
    output logic [SW-1:0] att_r,
    output logic [1:0]    ovf,
    output logic [DW-1:0] rdata
);
    logic [1:0] ovf_clr;

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel   <= 2'b11;
            gain  <= {1'b1, {(SW-1){1'b0}}, 1'b1, {(SW-1){1'b0}}};
            att_l <= '0;
            att_r <= '0;
        end else if (we) begin
            case (addr)
                A_SEL:   sel   <= wdata[1:0];
                A_GAIN:  gain  <= wdata[2*SW-1:0];
                A_ATTL:  att_l <= wdata[SW-1:0];
                A_ATTR:  att_r <= wdata[2*SW-1:SW];
                default: ;
            endcase
        end
    end

    // Clear mask from a write to the status address.
    assign ovf_clr = (we && addr == A_STAT) ? wdata[1:0] : 2'b00;

    // Sticky flags: clear on write-one, a new overflow wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 2'b00;
        else        ovf <= (ovf & ~ovf_clr) | ovf_set;
    end

    // Combinational readback of the addressed register.
    always_comb begin
        rdata = '0;
        case (addr)
            A_SEL:   rdata[1:0]       = sel;
            A_GAIN:  rdata[2*SW-1:0]  = gain;
            A_ATTL:  rdata[SW-1:0]    = att_l;
            A_ATTR:  rdata[2*SW-1:SW] = att_r;
            A_STAT:  rdata[1:0]       = ovf;
            default: rdata            = '0;
        endcase
    end
endmodule

// File: rtl/mix_sat_adder.sv
// Module: one channel of the saturating two-input adder. Each operand is
// gated by its enable; the sum is clamped to the signed W-bit range and the
// clamp is reported.
// Assumes two's-complement operands of equal width; purely combinational.
module mix_sat_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic         en_a,
    input  logic [W-1:0] b,
    input  logic         en_b,
    output logic [W-1:0] sum,
    output logic         clamped
);
    logic [W:0] wide;

    // Sign-extended sum of the enabled operands, one guard bit.
    always_comb begin
        wide = (en_a ? {a[W-1], a} : '0) + (en_b ? {b[W-1], b} : '0);
    end

    // Guard bit differing from the sign bit means the W-bit range was left.
    assign clamped = wide[W] ^ wide[W-1];

    // Clamp toward the limit on the side of the true sign.
    always_comb begin
        if (clamped) sum = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else         sum = wide[W-1:0];
    end
endmodule

// File: rtl/mix_atten.sv
// Module: one channel of the stepwise attenuator. The sample is multiplied by
// a Q15 coefficient picked by the step and the product is truncated toward
// zero.
// Assumes coefficients no larger than 1.0 so the result fits in W bits;
// purely combinational.
module mix_atten
    import mixer_pkg::*;
#(
    parameter int W  = SAMPLE_W,
    parameter int SW = STEP_W
) (
    input  logic [W-1:0]  sample,
    input  logic [SW-1:0] step,
    output logic [W-1:0]  result
);
    localparam int PW = W + COEF_W + 1;
    localparam logic signed [PW-1:0] BIAS = PW'((1 << COEF_FRAC) - 1);

    logic signed [PW-1:0] samp_x;
    logic signed [PW-1:0] coef_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;

    // Widen the operands and form the product.
    always_comb begin
        samp_x = PW'($signed(sample));
        coef_x = PW'(atten_coef(step));
        prod   = samp_x * coef_x;
    end

    // A negative product gets a bias before the shift so it rounds toward zero.
    assign biased = prod[PW-1] ? prod + BIAS : prod;
    assign result = W'(biased >>> COEF_FRAC);
endmodule

// File: rtl/codec_out_mixer.sv
// Module: top of the codec output mixer. Stage 1 registers the selected and
// saturated per-channel sum and raises the overflow flags; stage 2 registers
// the attenuated result. Channel index 1 is left, 0 is right.
// Assumes the select and attenuation settings stay put while a sample is in
// the pipeline.
module codec_out_mixer
    import mixer_pkg::*;
#(
    parameter int SAMPLE_BITS = SAMPLE_W,
    parameter int STEP_BITS   = STEP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic                   in_valid,
    input  logic [SAMPLE_BITS-1:0] adc_l,
    input  logic [SAMPLE_BITS-1:0] adc_r,
    input  logic [SAMPLE_BITS-1:0] mux_l,
    input  logic [SAMPLE_BITS-1:0] mux_r,
    output logic                   out_valid,
    output logic [SAMPLE_BITS-1:0] out_l,
    output logic [SAMPLE_BITS-1:0] out_r,
    output logic [1:0]             ovf_flags,
    output logic [STEP_BITS-1:0]   gain_l,
    output logic [STEP_BITS-1:0]   gain_r
);
    localparam int NCH = 2;

    logic [1:0]                           sel_q;
    logic [2*STEP_BITS-1:0]               gain_q;
    logic [STEP_BITS-1:0]                 att_l_q, att_r_q;
    logic [NCH-1:0][SAMPLE_BITS-1:0]      adc_ch, mux_ch, sum_ch, att_ch;
    logic [NCH-1:0][SAMPLE_BITS-1:0]      mix_q, out_q;
    logic [NCH-1:0][STEP_BITS-1:0]        step_ch;
    logic [NCH-1:0]                       clamp_ch;
    logic                                 mid_valid;

    assign adc_ch  = {adc_l, adc_r};
    assign mux_ch  = {mux_l, mux_r};
    assign step_ch = {att_l_q, att_r_q};

    mix_regs #(.AW(ADDR_W), .DW(DATA_W), .SW(STEP_BITS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ovf_set (clamp_ch & {NCH{in_valid}}),
        .sel     (sel_q),
        .gain    (gain_q),
        .att_l   (att_l_q),
        .att_r   (att_r_q),
        .ovf     (ovf_flags),
        .rdata   (reg_rdata)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        mix_sat_adder #(.W(SAMPLE_BITS)) u_add (
            .a       (adc_ch[ch]),
            .en_a    (sel_q[0]),
            .b       (mux_ch[ch]),
            .en_b    (sel_q[1]),
            .sum     (sum_ch[ch]),
            .clamped (clamp_ch[ch])
        );

        mix_atten #(.W(SAMPLE_BITS), .SW(STEP_BITS)) u_att (
            .sample (mix_q[ch]),
            .step   (step_ch[ch]),
            .result (att_ch[ch])
        );
    end

    // Stage 1: capture the saturated mix of an accepted sample pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_q     <= '0;
            mid_valid <= 1'b0;
        end else begin
            mid_valid <= in_valid;
            if (in_valid) mix_q <= sum_ch;
        end
    end

    // Stage 2: capture the attenuated pair and present it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= mid_valid;
            if (mid_valid) out_q <= att_ch;
        end
    end

    assign out_l  = out_q[1];
    assign out_r  = out_q[0];
    assign gain_l = gain_q[2*STEP_BITS-1:STEP_BITS];
    assign gain_r = gain_q[STEP_BITS-1:0];
endmodule

// File: rtl/mixer_checker.sv
// Module: property checker for the codec output mixer, attached to the top
// through bind. Observes ports and the stage-1 mix and select state.
// Assumes in_valid and reg_we are low during reset.
module mixer_checker
    import mixer_pkg::*;
#(
    parameter int W  = SAMPLE_W,
    parameter int SW = STEP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              in_valid,
    input logic              out_valid,
    input logic [1:0]        ovf_flags,
    input logic [SW-1:0]     gain_l,
    input logic [SW-1:0]     gain_r,
    input logic [1:0]        sel,
    input logic [W-1:0]      mix_l,
    input logic [W-1:0]      mix_r
);
    logic stat_wr;
    assign stat_wr = reg_we && reg_addr == A_STAT;

    AST_PIPE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2
    AST_PIPE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R2
    AST_SILENT_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == 2'b00) |=> (mix_l == '0 && mix_r == '0)); // R3
    AST_RIGHT_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flags[0]) |-> $past(in_valid && sel == 2'b11)); // R5
    AST_LEFT_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flags[1]) |-> $past(in_valid && sel == 2'b11)); // R5
    AST_RIGHT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flags[0] && !(stat_wr && reg_wdata[0])) |=> ovf_flags[0]); // R6
    AST_LEFT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flags[1] && !(stat_wr && reg_wdata[1])) |=> ovf_flags[1]); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[1:0] == 2'b11 && !in_valid) |=> ovf_flags == 2'b00); // R6
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == A_GAIN) |=> $stable({gain_l, gain_r})); // R9
endmodule

bind codec_out_mixer mixer_checker #(.W(SAMPLE_BITS), .SW(STEP_BITS)) u_mixer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .ovf_flags (ovf_flags),
    .gain_l    (gain_l),
    .gain_r    (gain_r),
    .sel       (sel_q),
    .mix_l     (mix_q[1]),
    .mix_r     (mix_q[0])
);

// File: tb/test_codec_out_mixer.sv
module test_codec_out_mixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        in_valid = 1'b0;
    logic [15:0] adc_l = '0, adc_r = '0, mux_l = '0, mux_r = '0;
    logic        out_valid;
    logic [15:0] out_l, out_r;
    logic [1:0]  ovf_flags;
    logic [3:0]  gain_l, gain_r;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    codec_out_mixer i_codec_out_mixer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .adc_l(adc_l), .adc_r(adc_r), .mux_l(mux_l), .mux_r(mux_r),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
        .ovf_flags(ovf_flags), .gain_l(gain_l), .gain_r(gain_r)
    );

    int vals[8] = '{0, 1, -1, 32767, -32768, 16384, -16385, 12345};
    int coef[16] = '{32768, 27570, 23197, 19518, 16422, 13818, 11626, 9782,
                     8230, 6925, 5827, 4902, 4125, 3470, 2920, 2457};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    // Present one sample pair, then wait until it is at the output.
    task automatic send(input int al, input int ar, input int ml, input int mr);
        @(negedge clk);
        adc_l = 16'(al); adc_r = 16'(ar); mux_l = 16'(ml); mux_r = 16'(mr);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid low after one cycle", int'(out_valid), 0);
        @(negedge clk);
        check("R2 valid after two cycles", int'(out_valid), 1);
    endtask

    function automatic int sat16(input int s);
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    function automatic int attn(input int x, input int k);
        longint p;
        p = longint'(x) * longint'(coef[k]);
        return int'(p / 64'sd32768);
    endfunction

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_l", int'($signed(out_l)), 0);
        check("R1 out_r", int'($signed(out_r)), 0);
        check("R1 gain_l", int'(gain_l), 8);
        check("R1 gain_r", int'(gain_r), 8);
        rd(3'd0, d); check("R1 select", d, 8'h03);
        rd(3'd1, d); check("R1 gain", d, 8'h88);
        rd(3'd2, d); check("R1 left atten", d, 0);
        rd(3'd3, d); check("R1 right atten", d, 0);
        rd(3'd4, d); check("R1 status", d, 0);

        // R3 R4 R5: every select code over a value grid, unity attenuation
        for (int s = 0; s < 4; s++) begin
            wr(3'd0, 8'(s));
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    int a, b, el, er, ef;
                    a = vals[i]; b = vals[j];
                    el = ((s & 1) ? a : 0) + ((s & 2) ? b : 0);
                    er = ((s & 1) ? b : 0) + ((s & 2) ? a : 0);
                    ef = ((el != sat16(el)) ? 2 : 0) + ((er != sat16(er)) ? 1 : 0);
                    send(a, b, b, a);
                    check("R3 R4 left mix", int'($signed(out_l)), sat16(el));
                    check("R3 R4 right mix", int'($signed(out_r)), sat16(er));
                    check("R5 overflow flags", int'(ovf_flags), ef);
                    if (ef != 0) begin
                        rd(3'd4, d); check("R5 status readback", d, ef);
                        wr(3'd4, 8'h03);
                        check("R6 clear both", int'(ovf_flags), 0);
                    end
                end
            end
        end

        // R7 R8: every attenuation step on both channels, ADC stream alone
        wr(3'd0, 8'h01);
        for (int k = 0; k < 16; k++) begin
            wr(3'd2, 8'hF0 | 8'(k));
            wr(3'd3, 8'((15 - k) << 4) | 8'h0F);
            rd(3'd2, d); check("R7 left field", d, k);
            rd(3'd3, d); check("R7 right field", d, (15 - k) << 4);
            for (int i = 0; i < 8; i++) begin
                send(vals[i], vals[(i + 3) % 8], 0, 0);
                check("R8 left attenuated", int'($signed(out_l)), attn(vals[i], k));
                check("R8 right attenuated", int'($signed(out_r)), attn(vals[(i + 3) % 8], 15 - k));
            end
        end
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);

        // R6: stickiness, partial clear, set wins over clear
        wr(3'd0, 8'h03);
        send(32767, -32768, 1, -1);
        check("R6 both set", int'(ovf_flags), 3);
        send(0, 0, 0, 0);
        check("R6 sticky without clear", int'(ovf_flags), 3);
        wr(3'd4, 8'h01);
        check("R6 clear right only", int'(ovf_flags), 2);
        wr(3'd4, 8'h00);
        check("R6 zero write keeps", int'(ovf_flags), 2);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h03;
        adc_l = 16'd0; mux_l = 16'd0; adc_r = 16'(-30000); mux_r = 16'(-30000);
        in_valid = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        check("R6 set wins over clear", int'(ovf_flags), 1);
        wr(3'd4, 8'h03);

        // R3 extra select bits dropped
        wr(3'd0, 8'hFE);
        rd(3'd0, d); check("R3 select stores two bits", d, 2);

        // R9 gain
        wr(3'd1, 8'h3C);
        check("R9 gain_l", int'(gain_l), 3);
        check("R9 gain_r", int'(gain_r), 12);
        rd(3'd1, d); check("R9 gain readback", d, 8'h3C);

        // R10 unmapped addresses
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), d); check("R10 unmapped reads zero", d, 0);
        end
        rd(3'd0, d); check("R10 select untouched", d, 2);
        rd(3'd1, d); check("R10 gain untouched", d, 8'h3C);
        rd(3'd2, d); check("R10 left atten untouched", d, 0);
        rd(3'd3, d); check("R10 right atten untouched", d, 0);
        rd(3'd4, d); check("R10 status untouched", d, 0);
        check("R10 gain pins untouched", int'({gain_l, gain_r}), 8'h3C);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule